// File: doc/BRIEF.md
# Synchronous Serial Position Command Receiver

This block listens to a legacy two-wire synchronous serial link (a bit clock and a data line) that carries servo position commands. It never drives that link. Both lines are oversampled by a fast local sample clock. Each line passes through a multi-stage synchronizer. The bit clock then goes through a glitch filter, so a level change counts only once it has persisted. Rising edges of the filtered bit clock shift data in. The receiver searches for a fixed 8-bit marker. Once the marker is found, the next 16 bits form one position word.

Each completed word is offered to the write port of an external dual-clock FIFO. If that FIFO reports full, the word is dropped and a sticky overflow flag records the loss. The block aborts a frame when the bit clock stops partway through it, and counts each abort in a saturating framing-error counter.

A command-loss watchdog counts sample-clock cycles since the last completed frame. When the count reaches its limit, the watchdog raises a reset toward the servo drives. The next completed frame releases that reset.

Top module: `scmd_rx_top`

## Requirements
- R1: While reset is active and immediately after it, fifo_wr_o, drv_rst_o and ovf_o are 0 and frm_err_o is 0.
- R2: A change on the bit-clock line is accepted only once the synchronized level has differed from the filtered level for 3 consecutive samples. Pulses lasting 1 or 2 samples add no bit.
- R3: Bits are taken MSB first on accepted rising edges of the bit clock. After the 8-bit marker 0xA5, the next 16 bits form the position word presented on fifo_data_o.
- R4: Bits that are not preceded by a complete 0xA5 marker produce no FIFO write. A 0xA5 value inside the data bits is treated as data.
- R5: Each completed word gives exactly one single-cycle fifo_wr_o pulse in a cycle where fifo_full_i is 0.
- R6: If the bit clock shows no accepted edge for EDGE_TMO sample cycles during the data bits, the frame is discarded and frm_err_o increments by one. Marker search then restarts.
- R7: frm_err_o saturates at 2^ERR_W-1.
- R8: A word completed while fifo_full_i is 1 is not written, and ovf_o is set. ovf_o stays 1 until ovf_clr_i is pulsed.
- R9: drv_rst_o goes to 1 when WDOG_LIMIT sample cycles pass without a completed frame, and returns to 0 in the cycle after a frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Legacy bit clock, asynchronous |
| ser_dat_i | input | 1 | Legacy data line, asynchronous |
| fifo_full_i | input | 1 | Full flag of the external FIFO write side |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | WORD_W | Position word |
| frm_err_o | output | ERR_W | Saturating framing-error count |
| ovf_o | output | 1 | Sticky overflow flag |
| drv_rst_o | output | 1 | Reset toward the servo drives |

## Verification
The bench shortens the watchdog limit to 3000 cycles. This lets a command-loss trip and its release happen within a short run. It narrows ERR_W to 2 so that four aborted frames reach counter saturation. The remaining parameters keep their defaults: a 3-sample glitch filter, a 64-cycle edge timeout and the 0xA5 marker. The bench also injects 1- and 2-sample glitches on the bit clock.

// File: rtl/scmd_rx_pkg.sv
package scmd_rx_pkg;
   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_DATA = 1'b1
   } frm_state_e;
endpackage

// File: rtl/scmd_rx_sync.sv
module scmd_rx_sync #(
   parameter int STAGES = 2,
   parameter int LANES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] async_i,
   output logic [LANES-1:0] sync_o
);
   initial assert (STAGES >= 2) else $error("STAGES must be at least 2");

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], async_i[l]};
      end
      assign sync_o[l] = chain[STAGES-1];
   end
endmodule

// File: rtl/scmd_rx_edge.sv
module scmd_rx_edge #(
   parameter int STABLE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_s,
   input  logic dat_s,
   output logic bit_v,
   output logic bit_d,
   output logic any_edge
);
   localparam int CW = $clog2(STABLE + 1);

   initial assert (STABLE >= 3) else $error("STABLE must be at least 3");

   logic          filt;
   logic [CW-1:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filt     <= 1'b0;
         run      <= '0;
         bit_v    <= 1'b0;
         bit_d    <= 1'b0;
         any_edge <= 1'b0;
      end else begin
         bit_v    <= 1'b0;
         any_edge <= 1'b0;
         if (clk_s == filt) begin
            run <= '0;
         end else if (run == CW'(STABLE - 1)) begin
            run      <= '0;
            filt     <= clk_s;
            any_edge <= 1'b1;
            if (clk_s) begin
               bit_v <= 1'b1;
               bit_d <= dat_s;
            end
         end else begin
            run <= run + 1'b1;
         end
      end
   end

   // R2: the filtered level only moves to a value held by the input over the last two samples
   a_r2_glitch_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (filt != $past(filt)) |-> ($past(clk_s) == filt && $past(clk_s, 2) == filt));
endmodule

// File: rtl/scmd_rx_framer.sv
module scmd_rx_framer
   import scmd_rx_pkg::*;
#(
   parameter int          WORD_W   = 16,
   parameter int          SYNC_W   = 8,
   parameter logic [SYNC_W-1:0] SYNC_PAT = 8'hA5,
   parameter int          EDGE_TMO = 64,
   parameter int          ERR_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_v,
   input  logic              bit_d,
   input  logic              any_edge,
   output logic              done,
   output logic [WORD_W-1:0] word,
   output logic [ERR_W-1:0]  err_cnt
);
   localparam int BCW = $clog2(WORD_W);
   localparam int ICW = $clog2(EDGE_TMO + 1);

   initial assert (SYNC_W >= 2 && WORD_W >= 2) else $error("widths too small");
   initial assert (EDGE_TMO >= 8) else $error("EDGE_TMO too small");

   frm_state_e        state;
   logic [SYNC_W-1:0] hunt_sh;
   logic [SYNC_W-1:0] hunt_nx;
   logic [BCW-1:0]    bcnt;
   logic [ICW-1:0]    idle;

   assign hunt_nx = {hunt_sh[SYNC_W-2:0], bit_d};

   always_ff @(posedge clk) begin
      if (!rst_n) idle <= '0;
      else if (any_edge) idle <= '0;
      else if (idle != ICW'(EDGE_TMO)) idle <= idle + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_HUNT;
         hunt_sh <= '0;
         bcnt    <= '0;
         word    <= '0;
         done    <= 1'b0;
         err_cnt <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_HUNT: begin
               if (bit_v) begin
                  if (hunt_nx == SYNC_PAT) begin
                     state   <= ST_DATA;
                     hunt_sh <= '0;
                     bcnt    <= '0;
                  end else begin
                     hunt_sh <= hunt_nx;
                  end
               end
            end
            ST_DATA: begin
               if (bit_v) begin
                  word <= {word[WORD_W-2:0], bit_d};
                  if (bcnt == BCW'(WORD_W - 1)) begin
                     done  <= 1'b1;
                     state <= ST_HUNT;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end else if (idle == ICW'(EDGE_TMO)) begin
                  state <= ST_HUNT;
                  if (err_cnt != '1) err_cnt <= err_cnt + 1'b1;
               end
            end
            default: state <= ST_HUNT;
         endcase
      end
   end

   // R5: a completed word is a single-cycle event
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: the error count never decreases
   a_r7_err_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (err_cnt >= $past(err_cnt)));
endmodule

// File: rtl/scmd_rx_wdog.sv
module scmd_rx_wdog #(
   parameter int LIMIT = 5_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic trip
);
   localparam int CW = $clog2(LIMIT + 1);

   initial assert (LIMIT >= 2) else $error("LIMIT too small");

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         trip <= 1'b0;
      end else if (kick) begin
         cnt  <= '0;
         trip <= 1'b0;
      end else if (cnt == CW'(LIMIT - 1)) begin
         trip <= 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R9: a completed frame releases the drive reset
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !trip);
   // R9: once tripped, the reset holds until a frame completes
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (trip && !kick) |=> trip);
endmodule

// File: rtl/scmd_rx_top.sv
module scmd_rx_top #(
   parameter int                 SYNC_STAGES = 2,
   parameter int                 STABLE      = 3,
   parameter int                 WORD_W      = 16,
   parameter int                 SYNC_W      = 8,
   parameter logic [SYNC_W-1:0]  SYNC_PAT    = 8'hA5,
   parameter int                 EDGE_TMO    = 64,
   parameter int                 ERR_W       = 8,
   parameter int                 WDOG_LIMIT  = 5_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              fifo_full_i,
   input  logic              ovf_clr_i,
   output logic              fifo_wr_o,
   output logic [WORD_W-1:0] fifo_data_o,
   output logic [ERR_W-1:0]  frm_err_o,
   output logic              ovf_o,
   output logic              drv_rst_o
);
   logic [1:0] lines_s;
   logic       bit_v, bit_d, any_edge, done;

   scmd_rx_sync #(.STAGES(SYNC_STAGES), .LANES(2)) u_sync (
      .clk, .rst_n,
      .async_i({ser_clk_i, ser_dat_i}),
      .sync_o (lines_s)
   );

   scmd_rx_edge #(.STABLE(STABLE)) u_edge (
      .clk, .rst_n,
      .clk_s   (lines_s[1]),
      .dat_s   (lines_s[0]),
      .bit_v   (bit_v),
      .bit_d   (bit_d),
      .any_edge(any_edge)
   );

   scmd_rx_framer #(
      .WORD_W(WORD_W), .SYNC_W(SYNC_W), .SYNC_PAT(SYNC_PAT),
      .EDGE_TMO(EDGE_TMO), .ERR_W(ERR_W)
   ) u_framer (
      .clk, .rst_n,
      .bit_v, .bit_d, .any_edge,
      .done   (done),
      .word   (fifo_data_o),
      .err_cnt(frm_err_o)
   );

   scmd_rx_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
      .clk, .rst_n,
      .kick(done),
      .trip(drv_rst_o)
   );

   assign fifo_wr_o = done & ~fifo_full_i;

   always_ff @(posedge clk) begin
      if (!rst_n)                    ovf_o <= 1'b0;
      else if (done && fifo_full_i)  ovf_o <= 1'b1;
      else if (ovf_clr_i)            ovf_o <= 1'b0;
   end

   // R8: the overflow flag holds until cleared
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !ovf_clr_i) |=> ovf_o);
   // R8: a drop always leaves the flag set
   a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fifo_full_i) |=> ovf_o);
endmodule

// File: tb/test_scmd_rx_top.sv
module test_scmd_rx_top;
   localparam int ERR_W = 2;
   localparam int WDOG  = 3000;
   localparam int HALF  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0, ser_dat = 1'b0, fifo_full = 1'b0, ovf_clr = 1'b0;
   logic        fifo_wr, ovf, drv_rst;
   logic [15:0] fifo_data;
   logic [ERR_W-1:0] frm_err;

   int n_run = 0, n_fail = 0;
   logic [15:0] exp_q[$];

   always #4 clk = ~clk;

   scmd_rx_top #(.ERR_W(ERR_W), .WDOG_LIMIT(WDOG)) i_scmd_rx_top (
      .clk, .rst_n,
      .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
      .fifo_full_i(fifo_full), .ovf_clr_i(ovf_clr),
      .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data),
      .frm_err_o(frm_err), .ovf_o(ovf), .drv_rst_o(drv_rst)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_bit(input logic b);
      ser_dat = b; ser_clk = 1'b0; cyc(HALF);
      ser_clk = 1'b1; cyc(HALF);
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic send_frame(input logic [15:0] w, input bit expect_wr);
      if (expect_wr) exp_q.push_back(w);
      send_bits(32'hA5, 8);
      send_bits({16'h0, w}, 16);
      ser_clk = 1'b0; cyc(2 * HALF);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && fifo_wr) begin
         if (exp_q.size() == 0) begin
            check("R4 unexpected write", int'(fifo_data), -1);
         end else begin
            check("R3 word", int'(fifo_data), int'(exp_q.pop_front()));
         end
      end
   end

   initial begin
      #1_600_000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      cyc(5);
      check("R1 wr", int'(fifo_wr), 0);
      check("R1 drvrst", int'(drv_rst), 0);
      check("R1 ovf", int'(ovf), 0);
      check("R1 err", int'(frm_err), 0);
      rst_n = 1'b1;
      cyc(2);
      check("R1 drvrst after reset", int'(drv_rst), 0);

      // R9: command loss trips the drive reset
      cyc(WDOG + 50);
      check("R9 trip", int'(drv_rst), 1);
      send_frame(16'h1234, 1'b1);
      check("R9 release", int'(drv_rst), 0);

      // R3: assorted words, one containing the marker value
      send_frame(16'hFFFF, 1'b1);
      send_frame(16'h0000, 1'b1);
      send_frame(16'hA5A5, 1'b1);
      send_frame(16'h8001, 1'b1);

      // R4: bits without the marker, then a partial marker, then a real frame
      send_bits(32'hFFFF_0F0F, 32);
      send_bits(32'h5A, 7);
      send_frame(16'hBEEF, 1'b1);
      check("R4 queue drained", exp_q.size(), 0);

      // R2: glitches of 1 and 2 samples during low phases
      exp_q.push_back(16'hC3A9);
      send_bits(32'hA5, 8);
      for (int i = 15; i >= 0; i--) begin
         ser_dat = 16'hC3A9 >> i; ser_clk = 1'b0; cyc(1);
         ser_clk = 1'b1; cyc((i % 2) + 1);
         ser_clk = 1'b0; cyc(HALF);
         ser_clk = 1'b1; cyc(HALF);
      end
      ser_clk = 1'b0; cyc(2 * HALF);
      check("R2 glitch frame", exp_q.size(), 0);

      // R6: stall partway through a frame
      send_bits(32'hA5, 8);
      send_bits(32'h15, 5);
      ser_clk = 1'b0; cyc(120);
      check("R6 abort count", int'(frm_err), 1);
      send_frame(16'h4242, 1'b1);
      check("R6 resync", exp_q.size(), 0);
      check("R6 count kept", int'(frm_err), 1);

      // R7: saturation after more aborts
      for (int k = 0; k < 3; k++) begin
         send_bits(32'hA5, 8);
         send_bits(32'h3, 2);
         ser_clk = 1'b0; cyc(120);
      end
      check("R7 saturate", int'(frm_err), 3);

      // R8: drop while full, stays set, clears on request
      fifo_full = 1'b1;
      send_frame(16'h7777, 1'b0);
      fifo_full = 1'b0;
      check("R8 ovf set", int'(ovf), 1);
      send_frame(16'h1357, 1'b1);
      check("R8 ovf sticky", int'(ovf), 1);
      check("R5 full frame not written", exp_q.size(), 0);
      ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0; cyc(1);
      check("R8 ovf cleared", int'(ovf), 0);
      check("R9 held off by frames", int'(drv_rst), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule